// File: doc/BRIEF.md
# NAND Page Sector ECC Engine

This block sits in the byte stream between a NAND flash controller's host side and its flash side. It protects each 512-byte sector of a page with a 24-bit Hamming-style check word. A small page holds one sector and a large page holds four. In the stream each sector is followed by its own 16-byte spare area, so one segment is 528 bytes. The page is set up with a start pulse, and the configuration inputs are sampled on that pulse. After that, page bytes arrive one per cycle whenever the valid strobe is high.

On a full-page write with code generation enabled, the engine accumulates the check word over the sector data. It then overwrites three bytes of the spare stream with that word. A mode bit chooses which three spare bytes are used.

On a full-page read with checking enabled, the engine does the following:
- It stores the sector data in an internal page buffer.
- It captures the stored check word from the spare area and compares it with the recomputed one.
- It flips a single wrong data bit back in the buffer.
- It records, per sector, whether the sector was correctable or uncorrectable, and it pulses a done strobe.

All of this happens while the spare bytes are still streaming. The host reads the corrected data through a buffer read port. A transfer flagged as not full-page passes through untouched and leaves the status alone.

Top module: `nand_page_ecc`

## Requirements
- R1: After reset, out_valid, done, corr_vec and uncorr_vec are all 0.
- R2: Every byte accepted on in_valid appears on out_byte with out_valid one clock later. It is unchanged unless R3 replaces it.
- R3: Check word bit layout. Number each data bit of a sector n = 8*byte_index + bit_index, a 12-bit value. Each set data bit toggles code bit 2k+n[k] for k = 0..11. On a write page with ecc_en and full set, spare byte 6+j of each sector leaves as code bits [8j+7:8j], for j = 0..2, when code_hi is 0.
- R4: With code_hi at 1, the check word occupies spare bytes 8, 9 and 10 in the same byte order. All other spare bytes pass unchanged.
- R5: When write, ecc_en or full is 0 for a page, no substitution happens and every spare byte passes unchanged.
- R6: On a checked read page, a single flipped data bit in a sector is restored in the page buffer. The buffer address of byte b of sector s is 512*s+b. The sector's corr_vec bit is set.
- R7: If only one bit of the stored check word is wrong, the sector's corr_vec bit is set, uncorr_vec stays clear, and the buffered data equals the data received.
- R8: Two flipped data bits in one sector set that sector's uncorr_vec bit, leave corr_vec clear and leave the buffered data uncorrected.
- R9: A clean sector leaves both of its vector bits clear, and the buffer holds exactly the received data.
- R10: On a checked read page, done is high for exactly one cycle. This cycle starts at the second clock edge after the last check-word byte of the final sector is accepted, when the status is already final. Pages that are not checked give no done.
- R11: The vectors are cleared only when a page starts with write=0, ecc_en=1 and full=1. They hold through idle time and through unchecked pages, and an unchecked read applies no correction.
- R12: Bit s of corr_vec and uncorr_vec belongs to sector s. A large page checks its four sectors independently, and a small page uses only sector 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_start | input | 1 | One-cycle pulse that opens a page and samples the cfg inputs |
| cfg_write | input | 1 | 1 = write page, 0 = read page |
| cfg_large | input | 1 | 1 = four sectors, 0 = one sector |
| cfg_code_hi | input | 1 | Check word at spare bytes 8..10 (1) or 6..8 (0) |
| cfg_ecc_en | input | 1 | Enables generation (write) or checking (read) |
| cfg_full | input | 1 | Page is a full-page transfer |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Input page byte |
| out_valid | output | 1 | Output byte strobe |
| out_byte | output | 8 | Output page byte, with check word inserted on writes |
| done | output | 1 | One-cycle pulse when all sectors of a checked read are judged |
| corr_vec | output | 4 | Per-sector correctable flags |
| uncorr_vec | output | 4 | Per-sector uncorrectable flags |
| buf_addr | input | 11 | Page buffer read address |
| buf_data | output | 8 | Page buffer read data |

## Verification
The sector check fires in the cycle after the last stored check-word byte is taken. In that same cycle the engine writes the bit correction into the page buffer and updates the status, while the next spare byte is being accepted and passed through. The bench streams every page back to back with no gaps, so each check cycle always overlaps a live byte. It then judges both functions at once: that passing spare byte must leave unchanged, and the buffer must show the repaired data once the page ends. On the final sector the done pulse also lands in that overlap, and the bench checks its exact byte position in the stream.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  // widest sector address the helpers accept (8 KiB sectors)
  localparam int MAX_AW = 13;
  localparam int MAX_CW = 2 * (MAX_AW + 3);

  typedef enum logic [1:0] {
    SEC_CLEAN     = 2'd0,
    SEC_DATA_FIX  = 2'd1,
    SEC_CODE_ONLY = 2'd2,
    SEC_BAD       = 2'd3
  } sec_class_e;

  // Contribution of one byte at a sector offset to the check word.
  // Pairs 0..2 follow the bit index inside the byte, pairs 3.. follow the
  // byte offset; the odd member of a pair covers the "1" half.
  function automatic logic [MAX_CW-1:0] byte_contrib(
      input logic [MAX_AW-1:0] addr,
      input logic [7:0]        d,
      input int                aw);
    logic [MAX_CW-1:0] r;
    logic par;
    r   = '0;
    par = ^d;
    for (int i = 0; i < 8; i++) begin
      if (d[i]) begin
        for (int k = 0; k < 3; k++) begin
          r[2*k + ((i >> k) & 1)] = ~r[2*k + ((i >> k) & 1)];
        end
      end
    end
    for (int j = 0; j < MAX_AW; j++) begin
      if ((j < aw) && par) begin
        r[2*(j+3) + int'(addr[j])] = ~r[2*(j+3) + int'(addr[j])];
      end
    end
    return r;
  endfunction

  // Sort a syndrome (stored xor computed) into one of four outcomes.
  function automatic sec_class_e classify(
      input logic [MAX_CW-1:0] syn,
      input int                pairs);
    int   ones;
    logic split_all;
    ones      = $countones(syn);
    split_all = 1'b1;
    for (int k = 0; k < MAX_AW + 3; k++) begin
      if ((k < pairs) && (syn[2*k] == syn[2*k+1])) split_all = 1'b0;
    end
    if (ones == 0)                          return SEC_CLEAN;
    else if (ones == 1)                     return SEC_CODE_ONLY;
    else if (split_all && (ones == pairs))  return SEC_DATA_FIX;
    else                                    return SEC_BAD;
  endfunction

endpackage

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum
  import nand_ecc_pkg::*;
#(
  parameter int AW     = 9,
  parameter int CODE_W = 2 * (AW + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_first,
  input  logic [AW-1:0]     acc_addr,
  input  logic [7:0]        acc_byte,
  output logic [CODE_W-1:0] code
);

  logic [CODE_W-1:0] step;
  logic [CODE_W-1:0] base;

  assign step = CODE_W'(byte_contrib(MAX_AW'(acc_addr), acc_byte, AW));
  assign base = acc_first ? '0 : code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code <= '0;
    end else if (acc_en) begin
      code <= base ^ step;
    end
  end

  // R3: the word only moves while sector bytes are accepted
  p_code_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> $stable(code));

endmodule

// File: rtl/nand_ecc_check.sv
module nand_ecc_check
  import nand_ecc_pkg::*;
#(
  parameter int AW     = 9,
  parameter int CODE_W = 2 * (AW + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_en,
  input  logic [CODE_W-1:0] calc_code,
  input  logic [CODE_W-1:0] read_code,
  output sec_class_e        verdict,
  output logic [AW-1:0]     err_addr,
  output logic [2:0]        err_bit
);

  localparam int PAIRS = AW + 3;

  logic [CODE_W-1:0] syndrome;
  logic [PAIRS-1:0]  where;

  assign syndrome = calc_code ^ read_code;
  assign verdict  = classify(MAX_CW'(syndrome), PAIRS);

  for (genvar k = 0; k < PAIRS; k++) begin : g_loc
    assign where[k] = syndrome[2*k+1];
  end

  assign err_bit  = where[2:0];
  assign err_addr = where[PAIRS-1:3];

  // R7: a check word that agrees with the data never asks for a repair
  p_clean_no_fix_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && (calc_code == read_code) |-> (verdict == SEC_CLEAN));

endmodule

// File: rtl/nand_page_buf.sv
module nand_page_buf #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          fix_en,
  input  logic [AW-1:0] fix_addr,
  input  logic [2:0]    fix_bit,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (fix_en) mem[fix_addr][fix_bit] <= ~mem[fix_addr][fix_bit];
  end

  assign rd_data = mem[rd_addr];

  // R6: a repair never lands on the entry being filled in the same cycle
  p_no_collide_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fix_en && wr_en |-> (fix_addr != wr_addr));

endmodule

// File: rtl/nand_page_ecc.sv
module nand_page_ecc
  import nand_ecc_pkg::*;
#(
  parameter int SECT_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int MAX_SECT    = 4,
  parameter int CODE_OFS_LO = 6,
  parameter int CODE_OFS_HI = 8,
  localparam int BUF_AW     = $clog2(MAX_SECT * SECT_BYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                page_start,
  input  logic                cfg_write,
  input  logic                cfg_large,
  input  logic                cfg_code_hi,
  input  logic                cfg_ecc_en,
  input  logic                cfg_full,
  input  logic                in_valid,
  input  logic [7:0]          in_byte,
  output logic                out_valid,
  output logic [7:0]          out_byte,
  output logic                done,
  output logic [MAX_SECT-1:0] corr_vec,
  output logic [MAX_SECT-1:0] uncorr_vec,
  input  logic [BUF_AW-1:0]   buf_addr,
  output logic [7:0]          buf_data
);

  localparam int AW     = $clog2(SECT_BYTES);
  localparam int CODE_W = 2 * (AW + 3);
  localparam int CB     = (CODE_W + 7) / 8;
  localparam int CBW    = CB * 8;
  localparam int SEG    = SECT_BYTES + SPARE_BYTES;
  localparam int PW     = $clog2(SEG);
  localparam int SW     = $clog2(MAX_SECT + 1);

  // page configuration held for the whole page
  logic          live_q;
  logic          rd_q, large_q, hi_q, gen_q, chk_q;
  logic [PW-1:0] pos_q;
  logic [SW-1:0] sect_q;
  logic [SW-1:0] nsec;

  // stream position events
  logic active, take, in_main, in_code, code_last;
  int   spare_rel, ofs, cb_sel;

  // code words
  logic [CODE_W-1:0] calc_code;
  logic [CBW-1:0]    calc_pad;
  logic [CBW-1:0]    stored_q;
  logic [7:0]        gen_byte;

  // check stage
  logic              chk_go_q, chk_last_q;
  logic [SW-1:0]     chk_sect_q;
  sec_class_e        verdict;
  logic [AW-1:0]     err_addr;
  logic [2:0]        err_bit;
  logic              fix_en, chk_fire, new_chk;
  logic [BUF_AW-1:0] fix_addr, wr_addr;
  logic              wr_en;

  logic                out_valid_q, done_q;
  logic [7:0]          out_byte_q;
  logic [MAX_SECT-1:0] corr_q, uncorr_q;

  assign nsec    = large_q ? SW'(MAX_SECT) : SW'(1);
  assign active  = live_q && (sect_q < nsec);
  assign take    = in_valid && active && !page_start;
  assign in_main = pos_q < PW'(SECT_BYTES);
  assign new_chk = cfg_ecc_en && cfg_full && !cfg_write;

  always_comb begin
    ofs       = hi_q ? CODE_OFS_HI : CODE_OFS_LO;
    spare_rel = int'(pos_q) - SECT_BYTES;
    in_code   = !in_main && (spare_rel >= ofs) && (spare_rel < ofs + CB);
    cb_sel    = in_code ? (spare_rel - ofs) : 0;
    code_last = in_code && (cb_sel == CB - 1);
  end

  assign calc_pad = CBW'(calc_code);

  always_comb begin
    gen_byte = calc_pad[7:0];
    for (int b = 0; b < CB; b++) begin
      if (cb_sel == b) gen_byte = calc_pad[b*8 +: 8];
    end
  end

  nand_ecc_accum #(.AW(AW), .CODE_W(CODE_W)) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (take && in_main),
    .acc_first (pos_q == '0),
    .acc_addr  (pos_q[AW-1:0]),
    .acc_byte  (in_byte),
    .code      (calc_code)
  );

  nand_ecc_check #(.AW(AW), .CODE_W(CODE_W)) u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_en    (chk_go_q),
    .calc_code (calc_code),
    .read_code (stored_q[CODE_W-1:0]),
    .verdict   (verdict),
    .err_addr  (err_addr),
    .err_bit   (err_bit)
  );

  assign chk_fire = chk_go_q;
  assign fix_en   = chk_go_q && (verdict == SEC_DATA_FIX);
  assign fix_addr = BUF_AW'(int'(chk_sect_q) * SECT_BYTES + int'(err_addr));
  assign wr_en    = take && in_main && rd_q;
  assign wr_addr  = BUF_AW'(int'(sect_q) * SECT_BYTES + int'(pos_q));

  nand_page_buf #(.DEPTH(MAX_SECT * SECT_BYTES), .AW(BUF_AW)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (in_byte),
    .fix_en   (fix_en),
    .fix_addr (fix_addr),
    .fix_bit  (err_bit),
    .rd_addr  (buf_addr),
    .rd_data  (buf_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q      <= 1'b0;
      rd_q        <= 1'b0;
      large_q     <= 1'b0;
      hi_q        <= 1'b0;
      gen_q       <= 1'b0;
      chk_q       <= 1'b0;
      pos_q       <= '0;
      sect_q      <= '0;
      stored_q    <= '0;
      chk_go_q    <= 1'b0;
      chk_last_q  <= 1'b0;
      chk_sect_q  <= '0;
      out_valid_q <= 1'b0;
      out_byte_q  <= '0;
      done_q      <= 1'b0;
      corr_q      <= '0;
      uncorr_q    <= '0;
    end else begin
      out_valid_q <= in_valid;
      out_byte_q  <= (take && gen_q && in_code) ? gen_byte : in_byte;
      done_q      <= chk_go_q && chk_last_q;
      if (page_start) begin
        live_q   <= 1'b1;
        rd_q     <= !cfg_write;
        large_q  <= cfg_large;
        hi_q     <= cfg_code_hi;
        gen_q    <= cfg_write && cfg_ecc_en && cfg_full;
        chk_q    <= new_chk;
        pos_q    <= '0;
        sect_q   <= '0;
        chk_go_q <= 1'b0;
        if (new_chk) begin
          corr_q   <= '0;
          uncorr_q <= '0;
        end
      end else begin
        if (take) begin
          if (pos_q == PW'(SEG - 1)) begin
            pos_q  <= '0;
            sect_q <= sect_q + SW'(1);
          end else begin
            pos_q <= pos_q + PW'(1);
          end
          for (int b = 0; b < CB; b++) begin
            if (in_code && (cb_sel == b)) stored_q[b*8 +: 8] <= in_byte;
          end
        end
        chk_go_q   <= take && chk_q && code_last;
        chk_sect_q <= sect_q;
        chk_last_q <= (sect_q == nsec - SW'(1));
        if (chk_fire) begin
          for (int s = 0; s < MAX_SECT; s++) begin
            if (chk_sect_q == SW'(s)) begin
              corr_q[s]   <= (verdict == SEC_DATA_FIX) || (verdict == SEC_CODE_ONLY);
              uncorr_q[s] <= (verdict == SEC_BAD);
            end
          end
        end
      end
    end
  end

  assign out_valid  = out_valid_q;
  assign out_byte   = out_byte_q;
  assign done       = done_q;
  assign corr_vec   = corr_q;
  assign uncorr_vec = uncorr_q;

  // R2: every accepted byte shows up one cycle later
  p_stream_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2: without generation the byte leaves untouched
  p_read_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !gen_q && !page_start |=> (out_byte == $past(in_byte)));

  // R10: done is a single-cycle strobe
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: done only follows a sector check
  p_done_after_chk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(chk_fire));

  // R11: status moves only at a check or a page start
  p_status_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !page_start && !chk_fire |=> $stable(corr_vec) && $stable(uncorr_vec));

  // R8: a sector is never both repaired and rejected
  p_flags_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fire |=> ((corr_vec & uncorr_vec) == '0));

endmodule

// File: tb/nand_page_ecc_bench.sv
module nand_page_ecc_bench;

  localparam int SB   = 512;
  localparam int SP   = 16;
  localparam int SEGL = SB + SP;
  localparam int NV   = 12;

  // {write, large, code_hi, ecc_en, full, err[1:0], seed[8:0]}
  // err: 0 none, 1 one data bit, 2 one code bit, 3 two data bits
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 9'd3},
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 9'd17},
    {1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 9'd40},
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 9'd5},
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 9'd6},
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 9'd7},
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 9'd91},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 9'd202},
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd2, 9'd155},
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3, 9'd66},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd3, 9'd301},
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 9'd77}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        page_start = 1'b0;
  logic        cfg_write = 1'b0, cfg_large = 1'b0, cfg_code_hi = 1'b0;
  logic        cfg_ecc_en = 1'b0, cfg_full = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        out_valid, done;
  logic [7:0]  out_byte;
  logic [3:0]  corr_vec, uncorr_vec;
  logic [10:0] buf_addr = '0;
  logic [7:0]  buf_data;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  nand_page_ecc u_nand_page_ecc (
    .clk(clk), .rst_n(rst_n), .page_start(page_start),
    .cfg_write(cfg_write), .cfg_large(cfg_large), .cfg_code_hi(cfg_code_hi),
    .cfg_ecc_en(cfg_ecc_en), .cfg_full(cfg_full),
    .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_byte(out_byte), .done(done),
    .corr_vec(corr_vec), .uncorr_vec(uncorr_vec),
    .buf_addr(buf_addr), .buf_data(buf_data)
  );

  logic [7:0]  good_dat [4][SB];
  logic [7:0]  exp_buf  [4][SB];
  logic [7:0]  stream   [4*SEGL];
  logic [7:0]  exp_out  [4*SEGL];
  logic [23:0] ref_code [4];
  logic [3:0]  exp_corr = '0, exp_unc = '0;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // restated code: each set bit at global index n toggles bit 2k+n[k]
  function automatic logic [23:0] sector_code(input int s);
    logic [23:0] c = '0;
    for (int a = 0; a < SB; a++) begin
      for (int i = 0; i < 8; i++) begin
        if (good_dat[s][a][i]) begin
          int n = a * 8 + i;
          for (int k = 0; k < 12; k++) c[2*k + ((n >> k) & 1)] ^= 1'b1;
        end
      end
    end
    return c;
  endfunction

  task automatic run_page(input logic [15:0] v, input string tag);
    logic w = v[15], lg = v[14], hi = v[13], ec = v[12], fl = v[11];
    logic [1:0] er = v[10:9];
    int seed = int'(v[8:0]);
    int nsec = lg ? 4 : 1;
    int ofs = hi ? 8 : 6;
    int esec = seed % nsec;
    int a1 = (seed * 5) % SB, b1 = seed % 8;
    int a2 = (a1 + 37) % SB, b2 = (b1 + 3) % 8;
    int total = nsec * SEGL;
    logic checked = !w && ec && fl;
    logic gen = w && ec && fl;
    int out_err = 0, done_cnt = 0, done_at = -1, exp_at;
    int buf_err = 0;

    for (int s = 0; s < nsec; s++) begin
      for (int a = 0; a < SB; a++)
        good_dat[s][a] = 8'((a * 7 + s * 53 + seed * 29) ^ (a >> 2) ^ (seed << 3));
      ref_code[s] = sector_code(s);
      for (int a = 0; a < SB; a++) begin
        stream[s*SEGL + a] = good_dat[s][a];
        exp_buf[s][a] = good_dat[s][a];
      end
      for (int p = 0; p < SP; p++) begin
        logic [7:0] filler = 8'(8'hC3 ^ (p * 17) ^ s);
        stream[s*SEGL + SB + p] = filler;
        if (!w && p >= ofs && p < ofs + 3)
          stream[s*SEGL + SB + p] = ref_code[s][(p-ofs)*8 +: 8];
      end
    end
    if (!w) begin
      if (er == 2'd1) begin
        stream[esec*SEGL + a1][b1] ^= 1'b1;
        if (!checked) exp_buf[esec][a1][b1] ^= 1'b1;
      end else if (er == 2'd2) begin
        stream[esec*SEGL + SB + ofs + (seed % 3)][b1] ^= 1'b1;
      end else if (er == 2'd3) begin
        stream[esec*SEGL + a1][b1] ^= 1'b1;
        stream[esec*SEGL + a2][b2] ^= 1'b1;
        exp_buf[esec][a1][b1] ^= 1'b1;
        exp_buf[esec][a2][b2] ^= 1'b1;
      end
    end
    for (int i = 0; i < total; i++) exp_out[i] = stream[i];
    if (gen) begin
      for (int s = 0; s < nsec; s++)
        for (int j = 0; j < 3; j++)
          exp_out[s*SEGL + SB + ofs + j] = ref_code[s][j*8 +: 8];
    end
    if (checked) begin
      exp_corr = '0;
      exp_unc = '0;
      if (er == 2'd1 || er == 2'd2) exp_corr[esec] = 1'b1;
      if (er == 2'd3) exp_unc[esec] = 1'b1;
    end

    cfg_write = w; cfg_large = lg; cfg_code_hi = hi; cfg_ecc_en = ec; cfg_full = fl;
    page_start = 1'b1;
    @(posedge clk); #1;
    page_start = 1'b0;
    for (int i = 0; i < total; i++) begin
      in_valid = 1'b1;
      in_byte = stream[i];
      @(posedge clk); #1;
      if (!out_valid || out_byte !== exp_out[i]) begin
        if (out_err == 0)
          $display("  byte %0d: got %0h expected %0h", i, out_byte, exp_out[i]);
        out_err++;
      end
      if (done) begin
        done_cnt++;
        done_at = i;
      end
    end
    in_valid = 1'b0;
    repeat (3) begin
      @(posedge clk); #1;
      if (done) done_cnt++;
    end
    check({tag, " stream R2 R3 R4 R5"}, out_err, 0);
    exp_at = (nsec - 1) * SEGL + SB + ofs + 3;
    check({tag, " done count R10"}, done_cnt, checked ? 1 : 0);
    if (checked) check({tag, " done position R10"}, done_at, exp_at);
    check({tag, " corr_vec R6 R7 R12 R11"}, {28'd0, corr_vec}, {28'd0, exp_corr});
    check({tag, " uncorr_vec R8 R12 R11"}, {28'd0, uncorr_vec}, {28'd0, exp_unc});
    if (!w) begin
      for (int s = 0; s < nsec; s++) begin
        for (int a = 0; a < SB; a++) begin
          buf_addr = 11'(s * SB + a);
          #1;
          if (buf_data !== exp_buf[s][a]) begin
            if (buf_err == 0)
              $display("  buf %0d/%0d: got %0h expected %0h", s, a, buf_data, exp_buf[s][a]);
            buf_err++;
          end
        end
      end
      check({tag, " buffer R6 R7 R8 R9"}, buf_err, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    check("reset out_valid R1", out_valid, 0);
    check("reset done R1", done, 0);
    check("reset vectors R1", {corr_vec, uncorr_vec}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    for (int v = 0; v < NV; v++) begin
      run_page(VEC[v], $sformatf("vec%0d", v));
    end

    // R11: status survives idle cycles
    repeat (5) @(posedge clk);
    #1;
    check("idle hold R11", {corr_vec, uncorr_vec}, {exp_corr, exp_unc});

    // R11: an unchecked write page start leaves status alone
    cfg_write = 1'b1; cfg_large = 1'b1; cfg_ecc_en = 1'b1; cfg_full = 1'b1;
    page_start = 1'b1;
    @(posedge clk); #1;
    page_start = 1'b0;
    check("write start hold R11", {corr_vec, uncorr_vec}, {exp_corr, exp_unc});

    // R11: a checked read page start clears status
    cfg_write = 1'b0;
    page_start = 1'b1;
    @(posedge clk); #1;
    page_start = 1'b0;
    check("read start clear R11", {corr_vec, uncorr_vec}, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule